// File: doc/BRIEF.md
# Generation-Tagged Address-Space Identifier Allocator

This block hands out address-space identifiers (ASIDs) to virtual CPUs on a single physical core. The aim is to avoid TLB invalidations. Each virtual CPU context keeps two values from its last assignment: the ASID it was given and the generation that was current then. On every guest entry, software presents that stored pair to the allocator, together with a flag that says whether the context wants its translations discarded. If the pair is still current and no discard was asked for, the context keeps its ASID. If not, the allocator gives out the next identifier from a round-robin pointer. A request to discard translations is therefore met with a new tag, not with an invalidation.

When the pointer moves past the configured top of the pool, the allocator starts a new generation, restarts the pointer at 1 and tells the caller to flush the whole TLB. Moving to a new generation makes every earlier tag stale at once, without touching any context. If the generation counter is already at its last value when this happens, tagging is turned off for good. From then on every entry gets the host identifier 0 and a flush demand, until reset. Identifier 0 is never given to a guest. The top of the pool is loaded once at core bring-up. Keeping the stored tags is the caller's job.

Top module: `asid_alloc`

## Requirements
- R1: After reset the current generation is 1, the round-robin pointer is 1, tagging is enabled and `rsp_valid` is low. The first request with a stale tag therefore receives ASID 1 in generation 1.
- R2: Every cycle with `req_valid` high produces exactly one response, with `rsp_valid` high on the following cycle. A cycle without a request leaves `rsp_valid` low on the following cycle.
- R3: Suppose the request's generation equals the current generation and `req_flush` is low. Then the response returns the request's own ASID and the current generation, with `rsp_need_flush` low, and the pointer does not move.
- R4: Suppose the request's generation differs from the current one and the pointer is not above the configured maximum. Then the response carries the pointer value as the ASID, with the current generation and `rsp_need_flush` low, and the pointer advances by one.
- R5: A request whose tag is current but whose `req_flush` is high is served exactly like a stale one (R4). It receives a new ASID, not a flush.
- R6: Suppose a new ASID is needed, the pointer is above the configured maximum, and the generation is below its all-ones value. Then the generation increments, the response carries ASID 1 with the new generation and `rsp_need_flush` high, and the next new ASID issued is 2.
- R7: While tagging is enabled, every response carries an ASID in the range 1 to the configured maximum, which must be at least 1.
- R8: Suppose a rollover is needed while the generation is all ones (generations run 1 to 2^GEN_W-1, and GEN_W is 64 by default). Then tagging is disabled. The response carries ASID 0 with `rsp_need_flush` and `rsp_disabled` high, and the generation stays where it is.
- R9: Once disabled, the block stays disabled until reset. Every response then carries ASID 0 with `rsp_need_flush` and `rsp_disabled` high, whatever tag or flush flag was presented.
- R10: A cycle with `cfg_load` high sets the pool maximum used by later requests. It moves neither the pointer nor the generation. If the new maximum is below the pointer, the next request that needs a new ASID rolls over (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_load | input | 1 | Load `cfg_max_asid` as the top of the pool |
| cfg_max_asid | input | ASID_W | Highest ASID the pool may issue (at least 1) |
| req_valid | input | 1 | Guest-entry request this cycle |
| req_gen | input | GEN_W | Generation stored in the context's tag |
| req_asid | input | ASID_W | ASID stored in the context's tag |
| req_flush | input | 1 | Context asks for its translations to be discarded |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_asid | output | ASID_W | ASID to run the guest with (0 when disabled) |
| rsp_gen | output | GEN_W | Generation to store back into the context's tag |
| rsp_need_flush | output | 1 | Whole TLB must be flushed before entry |
| rsp_disabled | output | 1 | Tagging is switched off |

## Verification
The bench builds the allocator with ASID_W=3 and GEN_W=3. It then loads pool maxima of 3, 7 and 2, so that only a handful of requests are needed to empty a generation. With three generation bits, the counter reaches its last value after seven generations. This brings the overflow shutdown and its stickiness within a few dozen cycles, which a 64-bit counter would never allow. Lowering the maximum below the live pointer exercises the rollover that a new configuration can cause.

// File: rtl/asid_alloc_pkg.sv
package asid_alloc_pkg;

  // Outcome chosen for one guest-entry request.
  typedef enum logic [1:0] {
    DEC_KEEP  = 2'd0,  // tag current, reuse it
    DEC_ISSUE = 2'd1,  // hand out pointer value
    DEC_ROLL  = 2'd2,  // pool exhausted, new generation
    DEC_OFF   = 2'd3   // tagging disabled (or becoming so)
  } asid_dec_e;

endpackage

// File: rtl/asid_decide.sv
module asid_decide
  import asid_alloc_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int GEN_W  = 64,
  localparam int PTR_W = ASID_W + 1
) (
  input  logic [GEN_W-1:0]  req_gen,
  input  logic              req_flush,
  input  logic [GEN_W-1:0]  cur_gen,
  input  logic [PTR_W-1:0]  next_ptr,
  input  logic [ASID_W-1:0] max_asid,
  input  logic              dis_q,
  output asid_dec_e         dec
);

  logic fresh;
  logic exhausted;
  logic gen_last;

  assign fresh     = (req_gen == cur_gen) && !req_flush;     // R3, R5
  assign exhausted = next_ptr > {1'b0, max_asid};             // R6, R10
  assign gen_last  = &cur_gen;                                // R8

  always_comb begin
    if (dis_q)          dec = DEC_OFF;                        // R9
    else if (fresh)     dec = DEC_KEEP;
    else if (!exhausted) dec = DEC_ISSUE;                     // R4
    else if (gen_last)  dec = DEC_OFF;
    else                dec = DEC_ROLL;
  end

endmodule

// File: rtl/asid_state.sv
module asid_state
  import asid_alloc_pkg::*;
#(
  parameter int ASID_W       = 8,
  parameter int GEN_W        = 64,
  parameter int RST_MAX_ASID = (1 << ASID_W) - 1,
  localparam int PTR_W       = ASID_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  asid_dec_e         dec,
  input  logic              cfg_load,
  input  logic [ASID_W-1:0] cfg_max_asid,
  output logic [GEN_W-1:0]  cur_gen,
  output logic [PTR_W-1:0]  next_ptr,
  output logic [ASID_W-1:0] max_asid,
  output logic              dis_q
);

  logic [GEN_W-1:0]  gen_d;
  logic [PTR_W-1:0]  ptr_d;
  logic [ASID_W-1:0] max_d;
  logic              dis_d;
  logic              upd_en;

  assign upd_en = req_valid | cfg_load;

  always_comb begin
    gen_d = cur_gen;
    ptr_d = next_ptr;
    dis_d = dis_q;
    max_d = cfg_load ? cfg_max_asid : max_asid;               // R10
    if (req_valid) begin
      unique case (dec)
        DEC_ISSUE: ptr_d = next_ptr + PTR_W'(1);              // R4
        DEC_ROLL: begin                                       // R6
          gen_d = cur_gen + GEN_W'(1);
          ptr_d = PTR_W'(2);
        end
        DEC_OFF:  dis_d = 1'b1;                               // R8, R9
        default:  ;                                           // keep: R3
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin                                         // R1
      cur_gen  <= GEN_W'(1);
      next_ptr <= PTR_W'(1);
      max_asid <= ASID_W'(RST_MAX_ASID);
      dis_q    <= 1'b0;
    end else if (upd_en) begin
      cur_gen  <= gen_d;
      next_ptr <= ptr_d;
      max_asid <= max_d;
      dis_q    <= dis_d;
    end
  end

endmodule

// File: rtl/asid_rsp.sv
module asid_rsp
  import asid_alloc_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int GEN_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  asid_dec_e         dec,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [ASID_W-1:0] issue_asid,
  input  logic [GEN_W-1:0]  cur_gen,
  output logic              rsp_valid,
  output logic [ASID_W-1:0] rsp_asid,
  output logic [GEN_W-1:0]  rsp_gen,
  output logic              rsp_need_flush,
  output logic              rsp_disabled
);

  logic [ASID_W-1:0] asid_d;
  logic [GEN_W-1:0]  gen_d;
  logic              flush_d;
  logic              dis_d;

  always_comb begin
    asid_d  = req_asid;
    gen_d   = cur_gen;
    flush_d = 1'b0;
    dis_d   = 1'b0;
    unique case (dec)
      DEC_ISSUE: asid_d = issue_asid;                         // R4, R5
      DEC_ROLL: begin                                         // R6
        asid_d  = ASID_W'(1);
        gen_d   = cur_gen + GEN_W'(1);
        flush_d = 1'b1;
      end
      DEC_OFF: begin                                          // R8, R9
        asid_d  = '0;
        flush_d = 1'b1;
        dis_d   = 1'b1;
      end
      default: ;                                              // R3
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;                       // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_asid       <= '0;
      rsp_gen        <= '0;
      rsp_need_flush <= 1'b0;
      rsp_disabled   <= 1'b0;
    end else if (req_valid) begin
      rsp_asid       <= asid_d;
      rsp_gen        <= gen_d;
      rsp_need_flush <= flush_d;
      rsp_disabled   <= dis_d;
    end
  end

endmodule

// File: rtl/asid_alloc.sv
module asid_alloc
  import asid_alloc_pkg::*;
#(
  parameter int ASID_W       = 8,
  parameter int GEN_W        = 64,
  parameter int RST_MAX_ASID = (1 << ASID_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ASID_W-1:0] cfg_max_asid,
  input  logic              req_valid,
  input  logic [GEN_W-1:0]  req_gen,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_flush,
  output logic              rsp_valid,
  output logic [ASID_W-1:0] rsp_asid,
  output logic [GEN_W-1:0]  rsp_gen,
  output logic              rsp_need_flush,
  output logic              rsp_disabled
);

  localparam int PTR_W = ASID_W + 1;

  asid_dec_e         dec;
  logic [GEN_W-1:0]  cur_gen;
  logic [PTR_W-1:0]  next_ptr;
  logic [ASID_W-1:0] max_asid;
  logic              dis_q;
  logic [ASID_W-1:0] issue_asid;

  assign issue_asid = next_ptr[ASID_W-1:0];

  asid_decide #(.ASID_W(ASID_W), .GEN_W(GEN_W)) u_decide (
    .req_gen   (req_gen),
    .req_flush (req_flush),
    .cur_gen   (cur_gen),
    .next_ptr  (next_ptr),
    .max_asid  (max_asid),
    .dis_q     (dis_q),
    .dec       (dec)
  );

  asid_state #(.ASID_W(ASID_W), .GEN_W(GEN_W), .RST_MAX_ASID(RST_MAX_ASID)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .dec          (dec),
    .cfg_load     (cfg_load),
    .cfg_max_asid (cfg_max_asid),
    .cur_gen      (cur_gen),
    .next_ptr     (next_ptr),
    .max_asid     (max_asid),
    .dis_q        (dis_q)
  );

  asid_rsp #(.ASID_W(ASID_W), .GEN_W(GEN_W)) u_rsp (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .dec            (dec),
    .req_asid       (req_asid),
    .issue_asid     (issue_asid),
    .cur_gen        (cur_gen),
    .rsp_valid      (rsp_valid),
    .rsp_asid       (rsp_asid),
    .rsp_gen        (rsp_gen),
    .rsp_need_flush (rsp_need_flush),
    .rsp_disabled   (rsp_disabled)
  );

endmodule

// File: rtl/asid_alloc_chk.sv
module asid_alloc_chk #(
  parameter int ASID_W = 8,
  parameter int GEN_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [GEN_W-1:0]  req_gen,
  input logic [ASID_W-1:0] req_asid,
  input logic              req_flush,
  input logic              rsp_valid,
  input logic [ASID_W-1:0] rsp_asid,
  input logic              rsp_need_flush,
  input logic              rsp_disabled,
  input logic [GEN_W-1:0]  cur_gen,
  input logic              dis_q
);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_keep_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dis_q && !req_flush && req_gen == cur_gen)
    |=> (rsp_asid == $past(req_asid) && !rsp_need_flush));

  p_gen_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_gen) |-> (cur_gen == $past(cur_gen) + GEN_W'(1)));

  p_roll_asid_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_need_flush && !rsp_disabled) |-> (rsp_asid == ASID_W'(1)));

  p_nonzero_asid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_disabled) |-> (rsp_asid != '0));

  p_off_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_disabled) |-> (rsp_asid == '0 && rsp_need_flush));

  p_sticky_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> dis_q);

endmodule

bind asid_alloc asid_alloc_chk #(.ASID_W(ASID_W), .GEN_W(GEN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_gen        (req_gen),
  .req_asid       (req_asid),
  .req_flush      (req_flush),
  .rsp_valid      (rsp_valid),
  .rsp_asid       (rsp_asid),
  .rsp_need_flush (rsp_need_flush),
  .rsp_disabled   (rsp_disabled),
  .cur_gen        (cur_gen),
  .dis_q          (dis_q)
);

// File: tb/asid_alloc_tb.sv
module asid_alloc_tb;

  localparam int AW   = 3;
  localparam int GW   = 3;
  localparam int GMAX = (1 << GW) - 1;
  localparam int NVC  = 4;

  logic          clk;
  logic          rst_n;
  logic          cfg_load;
  logic [AW-1:0] cfg_max_asid;
  logic          req_valid;
  logic [GW-1:0] req_gen;
  logic [AW-1:0] req_asid;
  logic          req_flush;
  logic          rsp_valid;
  logic [AW-1:0] rsp_asid;
  logic [GW-1:0] rsp_gen;
  logic          rsp_need_flush;
  logic          rsp_disabled;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // behavioural reference state
  int m_gen, m_next, m_max;
  bit m_dis;
  int tg_gen[NVC];
  int tg_asid[NVC];

  asid_alloc #(.ASID_W(AW), .GEN_W(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_max_asid(cfg_max_asid),
    .req_valid(req_valid), .req_gen(req_gen), .req_asid(req_asid), .req_flush(req_flush),
    .rsp_valid(rsp_valid), .rsp_asid(rsp_asid), .rsp_gen(rsp_gen),
    .rsp_need_flush(rsp_need_flush), .rsp_disabled(rsp_disabled)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cyc);
        finish_run();
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gen = 1; m_next = 1; m_max = (1 << AW) - 1; m_dis = 0;
  endtask

  // One cycle: drive at negedge, compare at next negedge.
  task automatic step(input bit v, input int vc, input bit fl, input string tag_ovr);
    int e_asid, e_gen; bit e_fl, e_dis; string tag;
    int max_now;
    max_now = m_max;
    cfg_load = 1'b0;
    req_valid = v;
    req_gen = GW'(tg_gen[vc]);
    req_asid = AW'(tg_asid[vc]);
    req_flush = fl;
    e_asid = 0; e_gen = m_gen; e_fl = 0; e_dis = 0; tag = "R2";
    if (v) begin
      if (m_dis) begin
        e_fl = 1; e_dis = 1; tag = "R9";
      end else if (tg_gen[vc] == m_gen && !fl) begin
        e_asid = tg_asid[vc]; tag = "R3";
      end else if (m_next > m_max) begin
        if (m_gen == GMAX) begin
          m_dis = 1; e_fl = 1; e_dis = 1; tag = "R8";
        end else begin
          m_gen++; e_gen = m_gen; e_asid = 1; m_next = 2; e_fl = 1; tag = "R6";
        end
      end else begin
        e_asid = m_next; m_next++;
        tag = (fl && tg_gen[vc] == m_gen) ? "R5" : "R4";
      end
      if (!e_dis) begin
        tg_gen[vc] = e_gen;
        tg_asid[vc] = e_asid;
      end
    end
    if (tag_ovr != "") tag = tag_ovr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == v, tag, "rsp_valid", rsp_valid, v);
    if (v) begin
      chk(rsp_asid == AW'(e_asid), tag, "rsp_asid", rsp_asid, e_asid);
      chk(rsp_need_flush == e_fl, tag, "rsp_need_flush", rsp_need_flush, e_fl);
      chk(rsp_disabled == e_dis, tag, "rsp_disabled", rsp_disabled, e_dis);
      if (!e_dis) begin
        chk(rsp_gen == GW'(e_gen), tag, "rsp_gen", rsp_gen, e_gen);
        // R7: enabled responses stay within 1..max
        chk(rsp_asid >= 1 && int'(rsp_asid) <= max_now, "R7", "asid range",
            rsp_asid, max_now);
      end
    end
  endtask

  task automatic load_max(input int mx);
    cfg_load = 1'b1;
    cfg_max_asid = AW'(mx);
    req_valid = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0;
    m_max = mx;
    chk(rsp_valid == 1'b0, "R10", "rsp_valid on load", rsp_valid, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    for (int i = 0; i < NVC; i++) begin tg_gen[i] = 0; tg_asid[i] = 0; end
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    chk(rsp_disabled == 1'b0, "R1", "rsp_disabled in reset", rsp_disabled, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int extra;
    rst_n = 1'b0; cfg_load = 1'b0; cfg_max_asid = '0;
    req_valid = 1'b0; req_gen = '0; req_asid = '0; req_flush = 1'b0;
    @(negedge clk);
    do_reset();

    load_max(3);
    step(1, 0, 0, "R1");      // first stale tag: asid 1, gen 1
    step(1, 1, 0, "");        // R4: asid 2
    step(1, 0, 0, "");        // R3: keeps 1
    step(0, 0, 0, "");        // R2: idle, no response
    step(1, 0, 1, "");        // R5: flush request gives asid 3
    step(1, 1, 0, "");        // R3: keeps 2
    step(1, 2, 0, "");        // R6: pool exhausted, gen 2, asid 1, flush
    step(1, 0, 0, "");        // R4: stale gen 1 -> asid 2

    load_max(7);
    step(1, 3, 0, "");        // asid 3, pointer now 4
    load_max(2);              // R10: maximum below pointer
    step(1, 1, 0, "R10");     // forces rollover to gen 3

    extra = 0;
    for (int i = 0; i < 200; i++) begin
      step(1, i % NVC, (i % 5) == 0, "");
      if (m_dis) extra++;
      if (extra > 3) break;
    end
    chk(m_dis == 1'b1, "R8", "model reached overflow", m_dis, 1);

    // R9: even a current-looking tag stays disabled
    tg_gen[0] = m_gen; tg_asid[0] = 1;
    step(1, 0, 0, "R9");
    step(1, 1, 1, "R9");

    do_reset();
    step(1, 2, 0, "R1");      // back to asid 1 gen 1
    finish_run();
  end

endmodule